// File: doc/BRIEF.md
# Stride-Predicting Load Address Table

This block guesses the data address of a load while the load instruction is still being fetched, so that a speculative read can start several cycles before the pipeline computes the real address. It is a direct-mapped table indexed by low bits of the fetch address. Each entry keeps a tag, the guessed next address, the last real address, a short signed stride and a one-bit inertia flag. On a tag match at fetch time the block raises a speculative read request with the guessed address in the same cycle.

Two cycles after the lookup, the execute stage presents the real address on the resolve port. One cycle later the block reports hit, squash or first-time miss. On a squash it gives the real address for a new read. At the end of that cycle it writes back the entry with the new stride, the new inertia state, the last real address and the next guess. A mode input chooses between plain stride replacement and an inertial filter, which needs two consecutive stride changes before it replaces the stored stride. Loads marked as not to be buffered pass through untouched. While an entry still has an update in flight, a new lookup that hits that entry raises a stall request instead of a read.

Top module: `load_addr_predictor`

## Requirements
- R1: The entry index is fetch address bits [IDX_W+1:2] (bits [5:2] by default). The tag is all bits above the index. A resolve whose tag differs from the resident tag at that index counts as a miss and replaces that entry, so the old address no longer predicts.
- R2: In the cycle of a lookup with `lk_valid`=1 and `lk_nobuf`=0 that matches a valid entry, and with no stall, `spec_req_valid` is 1 and `spec_req_addr` is that entry's guessed address. Otherwise `spec_req_valid` is 0.
- R3: A resolve presented in cycle t gives its result (`res_valid`=1) in cycle t+1. The entry is rewritten at the end of t+1, so lookups from cycle t+2 onward see the new contents.
- R4: When the entry matches, `res_hit` is 1 if the real address equals the stored guess. Otherwise `res_squash` is 1 and `redo_addr` carries the real address. The two flags are never 1 together.
- R5: When no valid entry matches, the result has `res_valid`=1 with both flags at 0. The entry is filled with the real address as both guess and last address, a stride of 0 and the inertia flag cleared.
- R6: On every matching resolve, the last address becomes the real address, and the next guess becomes the real address plus the sign-extended stride that is in force after the update.
- R7: With `inertial_en`=0, the stored stride is replaced on every matching resolve by (real address − last address), and the inertia flag is cleared.
- R8: With `inertial_en`=1, a stride that differs from the stored one sets the inertia flag and keeps the stored stride if the flag was clear. If the flag was already set, it replaces the stored stride and clears the flag.
- R9: With `inertial_en`=1, a stride that equals the stored one clears the inertia flag and keeps the stride.
- R10: A lookup with `lk_nobuf`=1 never raises a request or a stall. A resolve with `rs_nobuf`=1 gives no result and neither fills nor changes any entry.
- R11: A lookup that would hit an entry with an update in flight raises `stall_req` and no request. In flight means a non-stalled hitting lookup one or two cycles earlier, or a resolve still waiting to be written. The first lookup after the write proceeds normally.
- R12: Address arithmetic wraps modulo 2^32. The stride is stored as STRIDE_W-bit two's complement (8 bits by default). An observed stride is truncated to that width when stored and sign-extended when used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; invalidates all entries |
| inertial_en | input | 1 | 1 selects the inertial stride filter, 0 plain replacement |
| lk_valid | input | 1 | A load is being fetched this cycle |
| lk_pc | input | 32 | Fetch address of that load |
| lk_nobuf | input | 1 | Load is marked as not to be buffered |
| spec_req_valid | output | 1 | Speculative read request |
| spec_req_addr | output | 32 | Predicted data address for the speculative read |
| stall_req | output | 1 | Lookup hit an entry whose update is still in flight |
| rs_valid | input | 1 | Real address of a load is available |
| rs_pc | input | 32 | Instruction address of the resolving load |
| rs_addr | input | 32 | Real data address computed by execute |
| rs_nobuf | input | 1 | Resolving load is marked as not to be buffered |
| res_valid | output | 1 | A resolve result is reported this cycle |
| res_hit | output | 1 | The prediction was right |
| res_squash | output | 1 | The prediction was wrong; reissue at `redo_addr` |
| redo_addr | output | 32 | Real address for the replacement read |

## Verification
The hardest case to reach is a repeated lookup of one load while its own update is still in the pipe. The stimulus sets up an entry with a known stride. It then holds the same fetch address on the lookup port for five cycles in a row and presents the matching resolve in the third cycle. The stall has to come first from the lookup tracker, then from the pending write, and then clear with a guess that already includes the update. The inertia filter is driven with a sequence whose stride changes once, changes back, and restarts. This separates the set-then-replace and the equal-clears rules from plain replacement.

// File: rtl/lap_pkg.sv
`timescale 1ns/1ps
// Package: shared address width and result encoding for the load address
// predictor. Assumes 32-bit byte addresses throughout.
package lap_pkg;
    localparam int LAP_ADDR_W = 32;

    typedef logic [LAP_ADDR_W-1:0] lap_addr_t;

    // Outcome of one resolve once the entry has been read back.
    typedef enum logic [1:0] {
        LAP_RES_MISS   = 2'd0,
        LAP_RES_HIT    = 2'd1,
        LAP_RES_SQUASH = 2'd2
    } lap_res_e;
endpackage

// File: rtl/lap_table.sv
`timescale 1ns/1ps
// Module: lap_table
// Direct-mapped entry storage with one read port for lookups, one read port
// for the resolve stage and one write port. Only the valid bits are reset.
// The payload is don't-care until the first write to an entry.
module lap_table #(
    parameter int IDX_W    = 4,
    parameter int TAG_W    = 26,
    parameter int STRIDE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        la_idx,
    output logic                    la_valid,
    output logic [TAG_W-1:0]        la_tag,
    output lap_pkg::lap_addr_t      la_pred,
    input  logic [IDX_W-1:0]        lb_idx,
    output logic                    lb_valid,
    output logic [TAG_W-1:0]        lb_tag,
    output lap_pkg::lap_addr_t      lb_pred,
    output lap_pkg::lap_addr_t      lb_prev,
    output logic [STRIDE_W-1:0]     lb_stride,
    output logic                    lb_inert,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [TAG_W-1:0]        wr_tag,
    input  lap_pkg::lap_addr_t      wr_pred,
    input  lap_pkg::lap_addr_t      wr_prev,
    input  logic [STRIDE_W-1:0]     wr_stride,
    input  logic                    wr_inert
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]         vld_q;
    logic [TAG_W-1:0]         tag_q    [DEPTH];
    lap_pkg::lap_addr_t       pred_q   [DEPTH];
    lap_pkg::lap_addr_t       prev_q   [DEPTH];
    logic [STRIDE_W-1:0]      stride_q [DEPTH];
    logic [DEPTH-1:0]         inert_q;

    // Valid bits: cleared by reset, set on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    // Entry payload: overwritten in full on every write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            pred_q[wr_idx]   <= wr_pred;
            prev_q[wr_idx]   <= wr_prev;
            stride_q[wr_idx] <= wr_stride;
            inert_q[wr_idx]  <= wr_inert;
        end
    end

    // Lookup read port.
    assign la_valid  = vld_q[la_idx];
    assign la_tag    = tag_q[la_idx];
    assign la_pred   = pred_q[la_idx];

    // Resolve-stage read port.
    assign lb_valid  = vld_q[lb_idx];
    assign lb_tag    = tag_q[lb_idx];
    assign lb_pred   = pred_q[lb_idx];
    assign lb_prev   = prev_q[lb_idx];
    assign lb_stride = stride_q[lb_idx];
    assign lb_inert  = inert_q[lb_idx];
endmodule

// File: rtl/lap_update.sv
`timescale 1ns/1ps
// Module: lap_update
// Combinational rule for one resolve. It classifies the result as miss, hit
// or squash and forms the replacement entry. Assumes the entry read belongs
// to the index of the resolving load.
module lap_update #(
    parameter int TAG_W    = 26,
    parameter int STRIDE_W = 8
) (
    input  logic                    inertial,
    input  logic                    ent_valid,
    input  logic [TAG_W-1:0]        ent_tag,
    input  lap_pkg::lap_addr_t      ent_pred,
    input  lap_pkg::lap_addr_t      ent_prev,
    input  logic [STRIDE_W-1:0]     ent_stride,
    input  logic                    ent_inert,
    input  logic [TAG_W-1:0]        act_tag,
    input  lap_pkg::lap_addr_t      actual,
    output lap_pkg::lap_res_e       res,
    output lap_pkg::lap_addr_t      nxt_pred,
    output lap_pkg::lap_addr_t      nxt_prev,
    output logic [STRIDE_W-1:0]     nxt_stride,
    output logic                    nxt_inert
);
    import lap_pkg::*;
    localparam int EXT_W = LAP_ADDR_W - STRIDE_W;

    lap_addr_t observed;
    lap_addr_t stored_sx;
    lap_addr_t nxt_sx;
    logic      owner;

    assign owner     = ent_valid && (ent_tag == act_tag);
    assign observed  = actual - ent_prev;
    assign stored_sx = {{EXT_W{ent_stride[STRIDE_W-1]}}, ent_stride};
    assign nxt_sx    = {{EXT_W{nxt_stride[STRIDE_W-1]}}, nxt_stride};

    // Stride / inertia decision for the selected mode.
    always_comb begin
        nxt_stride = ent_stride;
        nxt_inert  = 1'b0;
        if (!owner) begin
            nxt_stride = '0;
        end else if (!inertial) begin
            nxt_stride = observed[STRIDE_W-1:0];
        end else if (observed == stored_sx) begin
            nxt_inert  = 1'b0;
        end else if (!ent_inert) begin
            nxt_inert  = 1'b1;
        end else begin
            nxt_stride = observed[STRIDE_W-1:0];
        end
    end

    // Result class and new addresses.
    always_comb begin
        nxt_prev = actual;
        if (!owner) begin
            res      = LAP_RES_MISS;
            nxt_pred = actual;
        end else begin
            res      = (ent_pred == actual) ? LAP_RES_HIT : LAP_RES_SQUASH;
            nxt_pred = actual + nxt_sx;
        end
    end
endmodule

// File: rtl/lap_track.sv
`timescale 1ns/1ps
// Module: lap_track
// Remembers the table index of each non-stalled hitting lookup for LEAD
// cycles, which is the fetch-to-resolve distance. Together with the pending
// write it raises a stall when a new hitting lookup targets one of those
// indices. Assumes every tracked lookup resolves exactly LEAD cycles later.
module lap_track #(
    parameter int IDX_W = 4,
    parameter int LEAD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             probe,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic             push,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    output logic             stall
);
    logic [LEAD-1:0]  sv_q;
    logic [IDX_W-1:0] si_q [LEAD];
    logic             busy;

    // Valid chain of tracked lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= '0;
        end else begin
            sv_q[0] <= push;
            for (int k = 1; k < LEAD; k++) sv_q[k] <= sv_q[k-1];
        end
    end

    // Index chain travelling alongside the valid chain.
    always_ff @(posedge clk) begin
        si_q[0] <= probe_idx;
        for (int k = 1; k < LEAD; k++) si_q[k] <= si_q[k-1];
    end

    // Any in-flight update on the probed index.
    always_comb begin
        busy = wb_valid && (wb_idx == probe_idx);
        for (int k = 0; k < LEAD; k++) begin
            if (sv_q[k] && (si_q[k] == probe_idx)) busy = 1'b1;
        end
    end

    assign stall = probe && busy;
endmodule

// File: rtl/load_addr_predictor.sv
`timescale 1ns/1ps
// Module: load_addr_predictor
// Top level. The fetch-side lookup drives the speculative read in the same
// cycle. The resolve port is registered into a write-back stage, which
// reports the result and rewrites the entry at the end of that cycle.
// Assumes the resolve of a load arrives LEAD cycles after its lookup.
module load_addr_predictor #(
    parameter int IDX_W    = 4,
    parameter int OFS_W    = 2,
    parameter int STRIDE_W = 8,
    parameter int LEAD     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inertial_en,
    input  logic        lk_valid,
    input  logic [31:0] lk_pc,
    input  logic        lk_nobuf,
    output logic        spec_req_valid,
    output logic [31:0] spec_req_addr,
    output logic        stall_req,
    input  logic        rs_valid,
    input  logic [31:0] rs_pc,
    input  logic [31:0] rs_addr,
    input  logic        rs_nobuf,
    output logic        res_valid,
    output logic        res_hit,
    output logic        res_squash,
    output logic [31:0] redo_addr
);
    import lap_pkg::*;
    localparam int TAG_W = LAP_ADDR_W - OFS_W - IDX_W;

    logic [IDX_W-1:0]    lk_idx;
    logic [TAG_W-1:0]    lk_tag;
    logic                a_valid;
    logic [TAG_W-1:0]    a_tag;
    lap_addr_t           a_pred;
    logic                lk_hit;
    logic                stall;

    logic                wb_valid_q;
    logic [IDX_W-1:0]    wb_idx_q;
    logic [TAG_W-1:0]    wb_tag_q;
    lap_addr_t           wb_act_q;

    logic                b_valid;
    logic [TAG_W-1:0]    b_tag;
    lap_addr_t           b_pred;
    lap_addr_t           b_prev;
    logic [STRIDE_W-1:0] b_stride;
    logic                b_inert;

    lap_res_e            res;
    lap_addr_t           n_pred;
    lap_addr_t           n_prev;
    logic [STRIDE_W-1:0] n_stride;
    logic                n_inert;

    logic                unused_pc_low;
    assign unused_pc_low = ^{lk_pc[OFS_W-1:0], rs_pc[OFS_W-1:0]};

    assign lk_idx = lk_pc[OFS_W +: IDX_W];
    assign lk_tag = lk_pc[LAP_ADDR_W-1 -: TAG_W];
    assign lk_hit = lk_valid && !lk_nobuf && a_valid && (a_tag == lk_tag);

    lap_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .STRIDE_W(STRIDE_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .la_idx    (lk_idx),
        .la_valid  (a_valid),
        .la_tag    (a_tag),
        .la_pred   (a_pred),
        .lb_idx    (wb_idx_q),
        .lb_valid  (b_valid),
        .lb_tag    (b_tag),
        .lb_pred   (b_pred),
        .lb_prev   (b_prev),
        .lb_stride (b_stride),
        .lb_inert  (b_inert),
        .wr_en     (wb_valid_q),
        .wr_idx    (wb_idx_q),
        .wr_tag    (wb_tag_q),
        .wr_pred   (n_pred),
        .wr_prev   (n_prev),
        .wr_stride (n_stride),
        .wr_inert  (n_inert)
    );

    lap_track #(.IDX_W(IDX_W), .LEAD(LEAD)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe     (lk_hit),
        .probe_idx (lk_idx),
        .push      (lk_hit && !stall),
        .wb_valid  (wb_valid_q),
        .wb_idx    (wb_idx_q),
        .stall     (stall)
    );

    // Write-back stage valid: only bufferable resolves enter.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_valid_q <= 1'b0;
        else        wb_valid_q <= rs_valid && !rs_nobuf;
    end

    // Write-back stage payload: captured with each accepted resolve.
    always_ff @(posedge clk) begin
        if (rs_valid && !rs_nobuf) begin
            wb_idx_q <= rs_pc[OFS_W +: IDX_W];
            wb_tag_q <= rs_pc[LAP_ADDR_W-1 -: TAG_W];
            wb_act_q <= rs_addr;
        end
    end

    lap_update #(.TAG_W(TAG_W), .STRIDE_W(STRIDE_W)) u_update (
        .inertial   (inertial_en),
        .ent_valid  (b_valid),
        .ent_tag    (b_tag),
        .ent_pred   (b_pred),
        .ent_prev   (b_prev),
        .ent_stride (b_stride),
        .ent_inert  (b_inert),
        .act_tag    (wb_tag_q),
        .actual     (wb_act_q),
        .res        (res),
        .nxt_pred   (n_pred),
        .nxt_prev   (n_prev),
        .nxt_stride (n_stride),
        .nxt_inert  (n_inert)
    );

    assign spec_req_valid = lk_hit && !stall;
    assign spec_req_addr  = a_pred;
    assign stall_req      = stall;
    assign res_valid      = wb_valid_q;
    assign res_hit        = wb_valid_q && (res == LAP_RES_HIT);
    assign res_squash     = wb_valid_q && (res == LAP_RES_SQUASH);
    assign redo_addr      = wb_act_q;
endmodule

// File: rtl/lap_checker.sv
`timescale 1ns/1ps
// Module: lap_checker
// Port-level temporal checks for load_addr_predictor, attached by bind.
module lap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic        lk_nobuf,
    input logic        spec_req_valid,
    input logic        stall_req,
    input logic        rs_valid,
    input logic        rs_nobuf,
    input logic [31:0] rs_addr,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_squash,
    input logic [31:0] redo_addr
);
    a_r2_req_from_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        spec_req_valid |-> (lk_valid && !lk_nobuf));

    a_r11_stall_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (!spec_req_valid && lk_valid));

    a_r10_nobuf_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_nobuf) |-> !stall_req);

    a_r10_nobuf_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_nobuf) |=> !res_valid);

    a_r3_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_nobuf) |=> res_valid);

    a_r3_result_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rs_valid && !rs_nobuf));

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_squash}) && ((res_hit || res_squash) -> res_valid));

    a_r4_redo_is_actual: assert property (@(posedge clk) disable iff (!rst_n)
        res_squash |-> (redo_addr == $past(rs_addr)));
endmodule

bind load_addr_predictor lap_checker u_lap_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_nobuf       (lk_nobuf),
    .spec_req_valid (spec_req_valid),
    .stall_req      (stall_req),
    .rs_valid       (rs_valid),
    .rs_nobuf       (rs_nobuf),
    .rs_addr        (rs_addr),
    .res_valid      (res_valid),
    .res_hit        (res_hit),
    .res_squash     (res_squash),
    .redo_addr      (redo_addr)
);

// File: tb/tb_load_addr_predictor.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver tasks push expected resolve outcomes and the
// monitor pops them as the design reports results.
module tb_load_addr_predictor;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inertial_en = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_nobuf = 1'b0;
    logic        spec_req_valid;
    logic [31:0] spec_req_addr;
    logic        stall_req;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic [31:0] rs_addr = '0;
    logic        rs_nobuf = 1'b0;
    logic        res_valid;
    logic        res_hit;
    logic        res_squash;
    logic [31:0] redo_addr;

    always #10 clk = ~clk;

    load_addr_predictor dut (
        .clk(clk), .rst_n(rst_n), .inertial_en(inertial_en),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_nobuf(lk_nobuf),
        .spec_req_valid(spec_req_valid), .spec_req_addr(spec_req_addr),
        .stall_req(stall_req),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_addr(rs_addr), .rs_nobuf(rs_nobuf),
        .res_valid(res_valid), .res_hit(res_hit), .res_squash(res_squash),
        .redo_addr(redo_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic        hit;
        logic        squash;
        logic [31:0] redo;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Reference entries built from the requirements.
    bit          m_v   [NE];
    logic [25:0] m_t   [NE];
    logic [31:0] m_p   [NE];
    logic [31:0] m_prv [NE];
    logic [7:0]  m_s   [NE];
    bit          m_i   [NE];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ix(logic [31:0] pc);
        return int'(pc[5:2]);
    endfunction

    function automatic logic [31:0] sx(logic [7:0] s);
        return {{24{s[7]}}, s};
    endfunction

    // Lookup in the current cycle; compare with the reference entries.
    task automatic look_model(logic [31:0] pc, logic nobuf, string tag);
        bit e;
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_nobuf = nobuf;
        #1;
        e = !nobuf && m_v[ix(pc)] && (m_t[ix(pc)] == pc[31:6]);
        chk({tag, " R2 req_valid"}, {31'd0, spec_req_valid}, {31'd0, e});
        if (e) chk({tag, " R2 req_addr"}, spec_req_addr, m_p[ix(pc)]);
        chk({tag, " R11 no stall"}, {31'd0, stall_req}, 32'd0);
    endtask

    // Lookup checked against literal values.
    task automatic look_lit(logic [31:0] pc, logic nobuf, logic ev, logic [31:0] ea, string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_nobuf = nobuf;
        #1;
        chk({tag, " req_valid"}, {31'd0, spec_req_valid}, {31'd0, ev});
        if (ev) chk({tag, " req_addr"}, spec_req_addr, ea);
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Apply the update rule to the reference and queue the expected result.
    task automatic model_resolve(logic [31:0] pc, logic [31:0] a, string tag);
        int i;
        exp_t e;
        logic [31:0] obs;
        i = ix(pc);
        e.tag = tag; e.redo = a;
        if (!(m_v[i] && m_t[i] == pc[31:6])) begin
            e.hit = 0; e.squash = 0;
            m_v[i] = 1; m_t[i] = pc[31:6]; m_p[i] = a; m_prv[i] = a; m_s[i] = '0; m_i[i] = 0;
        end else begin
            e.hit = (m_p[i] == a); e.squash = (m_p[i] != a);
            obs = a - m_prv[i];
            if (!inertial_en) begin
                m_s[i] = obs[7:0]; m_i[i] = 0;
            end else if (obs == sx(m_s[i])) begin
                m_i[i] = 0;
            end else if (!m_i[i]) begin
                m_i[i] = 1;
            end else begin
                m_s[i] = obs[7:0]; m_i[i] = 0;
            end
            m_prv[i] = a;
            m_p[i] = a + sx(m_s[i]);
        end
        sb_q.push_back(e);
    endtask

    // One load: lookup, gap, resolve two cycles later, gap.
    task automatic ld(logic [31:0] pc, logic [31:0] a, logic nobuf, string tag);
        look_model(pc, nobuf, tag);
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = pc; rs_addr = a; rs_nobuf = nobuf;
        if (!nobuf) model_resolve(pc, a, tag);
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per reported result.
    always begin
        @(negedge clk);
        #3;
        if (rst_n && res_valid && !finished) begin
            if (sb_q.size() == 0) begin
                chk("R10 unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " R4 hit"}, {31'd0, res_hit}, {31'd0, e.hit});
                chk({e.tag, " R4 squash"}, {31'd0, res_squash}, {31'd0, e.squash});
                if (e.squash) chk({e.tag, " R4 redo_addr"}, redo_addr, e.redo);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < NE; k++) m_v[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        look_lit(32'h0000_1004, 1'b0, 1'b0, 32'h0, "R2 reset no request");
        chk("R3 reset res_valid", {31'd0, res_valid}, 32'd0);
        chk("R11 reset stall", {31'd0, stall_req}, 32'd0);

        // R8: inertial stride walk with a restart.
        inertial_en = 1'b1;
        ld(32'h0000_1004, 32'h100, 0, "R5 alloc");
        ld(32'h0000_1004, 32'h104, 0, "R8 first change");
        ld(32'h0000_1004, 32'h108, 0, "R8 second change");
        ld(32'h0000_1004, 32'h10c, 0, "R6 stride walk");
        ld(32'h0000_1004, 32'h110, 0, "R6 stride walk");
        ld(32'h0000_1004, 32'h114, 0, "R6 stride walk");
        ld(32'h0000_1004, 32'h118, 0, "R6 stride walk");
        ld(32'h0000_1004, 32'h100, 0, "R8 restart keeps stride");
        look_lit(32'h0000_1004, 1'b0, 1'b1, 32'h104, "R8 inertial guess after restart");
        ld(32'h0000_1004, 32'h104, 0, "R8 hit after restart");

        // R9: equal stride clears inertia.
        ld(32'h0000_1018, 32'h100, 0, "R9 alloc");
        ld(32'h0000_1018, 32'h104, 0, "R9 set inertia");
        ld(32'h0000_1018, 32'h104, 0, "R9 equal clears");
        ld(32'h0000_1018, 32'h108, 0, "R9 change after clear");
        look_lit(32'h0000_1018, 1'b0, 1'b1, 32'h108, "R9 stride kept after clear");

        // R7: plain replacement.
        inertial_en = 1'b0;
        ld(32'h0000_2008, 32'h100, 0, "R7 alloc");
        ld(32'h0000_2008, 32'h104, 0, "R7 replace");
        ld(32'h0000_2008, 32'h108, 0, "R7 hit");
        ld(32'h0000_2008, 32'h118, 0, "R7 jump");
        ld(32'h0000_2008, 32'h100, 0, "R7 restart");
        look_lit(32'h0000_2008, 1'b0, 1'b1, 32'h0000_00e8, "R7 negative stride guess");

        // R1: same index, other tag displaces.
        ld(32'h0000_3004, 32'h7000, 0, "R1 conflict alloc");
        look_lit(32'h0000_1004, 1'b0, 1'b0, 32'h0, "R1 displaced entry");
        look_lit(32'h0000_3004, 1'b0, 1'b1, 32'h7000, "R1 new owner");

        // R10: non-bufferable loads are ignored.
        ld(32'h0000_100c, 32'h500, 1, "R10 nobuf new pc");
        look_lit(32'h0000_100c, 1'b0, 1'b0, 32'h0, "R10 no allocation");
        ld(32'h0000_2008, 32'h0999_9990, 1, "R10 nobuf on entry");
        look_lit(32'h0000_2008, 1'b0, 1'b1, 32'h0000_00e8, "R10 entry unchanged");
        look_lit(32'h0000_2008, 1'b1, 1'b0, 32'h0, "R10 nobuf lookup");

        // R12: wrap and truncated stride.
        ld(32'h0000_1010, 32'hffff_fff8, 0, "R12 alloc");
        ld(32'h0000_1010, 32'hffff_fffc, 0, "R12 stride");
        look_lit(32'h0000_1010, 1'b0, 1'b1, 32'h0000_0000, "R12 wrapped guess");
        ld(32'h0000_1010, 32'h0000_0000, 0, "R12 wrap hit");
        ld(32'h0000_1010, 32'h0000_0300, 0, "R12 wide stride");
        look_lit(32'h0000_1010, 1'b0, 1'b1, 32'h0000_0300, "R12 truncated stride");

        // R11 / R3: back-to-back lookups of one load.
        ld(32'h0000_1014, 32'h2000, 0, "R11 alloc");
        ld(32'h0000_1014, 32'h2010, 0, "R11 stride");
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = 32'h0000_1014; lk_nobuf = 1'b0;
        #1;
        chk("R11 first lookup req", {31'd0, spec_req_valid}, 32'd1);
        chk("R11 first lookup addr", spec_req_addr, 32'h2020);
        chk("R11 first lookup stall", {31'd0, stall_req}, 32'd0);
        @(negedge clk);
        #1;
        chk("R11 stall behind lookup", {31'd0, stall_req}, 32'd1);
        chk("R11 no req while stalled", {31'd0, spec_req_valid}, 32'd0);
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = 32'h0000_1014; rs_addr = 32'h2020; rs_nobuf = 1'b0;
        model_resolve(32'h0000_1014, 32'h2020, "R11 resolve");
        #1;
        chk("R11 stall in resolve cycle", {31'd0, stall_req}, 32'd1);
        @(negedge clk);
        rs_valid = 1'b0;
        #1;
        chk("R3 stall while write pending", {31'd0, stall_req}, 32'd1);
        @(negedge clk);
        #1;
        chk("R3 stall released", {31'd0, stall_req}, 32'd0);
        chk("R3 updated guess", spec_req_addr, 32'h2030);
        chk("R3 request after release", {31'd0, spec_req_valid}, 32'd1);
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (4) @(negedge clk);

        chk("R3 all results seen", sb_q.size(), 32'd0);
        finished = 1;
        summary();
        $finish;
    end
endmodule